// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block is a clocked model of the command front end of a byte-wide parallel NOR flash with an 18-bit address. Each write strobe lasts one clock cycle and carries an address and a data byte. The decoder follows the unlock-prefixed command protocol and acts on the commands it recognises. Byte program and chip erase change a small internal array. A lockout command permanently protects the boot region. An identification mode replaces the read data at a few low addresses with code bytes and the lock status.

The array holds 2^IDX_W bytes. The lower half stands for the boot region (addresses 00000h to 01FFFh), and the upper half stands for everything above it. Reads are combinational from `rd_addr`. After a program or erase, the block reports busy for a fixed number of cycles, and it drops every write it sees in that time.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset every array byte reads FFh, `busy` is 0, `id_mode` is 0 and `boot_locked` is 0.
- R2: The write sequence AAh@5555h, 55h@2AAAh, A0h@5555h, then D@A stores (old AND D) at location A. Bits can only go from 1 to 0.
- R3: The chip erase sequence AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h sets every byte to FFh while the block is unlocked.
- R4: The same six-cycle form with last data 40h sets `boot_locked`, which then stays 1 until reset. In ID mode a read of address 2 returns 01h when locked and 00h when unlocked.
- R5: While locked, a program to any address below 2000h is ignored and raises no busy, and a chip erase leaves the boot half unchanged.
- R6: AAh@5555h, 55h@2AAAh, 90h@5555h sets `id_mode`. Two sequences clear it: AAh@5555h, 55h@2AAAh, F0h@5555h, or a single F0h write at any address while no sequence is in progress. In ID mode, reads of address 0 and address 1 return MFR_CODE and DEV_CODE. Reads of other addresses return array data.
- R7: A write that does not match the expected next cycle returns the decoder to idle and leaves the array unchanged. That write does not itself start a new sequence.
- R8: An accepted program or erase makes `busy` 1 for exactly BUSY_CYC cycles, starting the cycle after the final write. Writes during those cycles are ignored.
- R9: The array location is chosen by {address >= 2000h, address[IDX_W-2:0]}. Addresses that share this index read the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 18 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 18 | Read address |
| rd_data | output | 8 | Read data (array or identification byte) |
| busy | output | 1 | Program or erase in progress |
| id_mode | output | 1 | Identification mode active |
| boot_locked | output | 1 | Boot region write lock |

## Verification
The hardest case to reach is a locked boot region meeting an erase. The boot half must already hold non-FFh data from before the lock, and the lock itself needs a full six-cycle sequence. The stimulus therefore first programs a boot byte and a main byte, then locks, then tries both a program and an erase. Timing is the second concern. Writes sent back to back straight after a program must all land inside the busy window, so the bench issues a complete four-cycle program on consecutive cycles and expects nothing to change.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int          IDX_W    = 5,
  parameter int          BUSY_CYC = 8,
  parameter logic [7:0]  MFR_CODE = 8'h1F,
  parameter logic [7:0]  DEV_CODE = 8'h0B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [17:0] wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [17:0] rd_addr,
  output logic [7:0]  rd_data,
  output logic        busy,
  output logic        id_mode,
  output logic        boot_locked
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int HALF  = DEPTH / 2;
  localparam int CW    = $clog2(BUSY_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_PGM, S_E3, S_E4, S_E5} st_t;

  function automatic logic [IDX_W-1:0] idx(input logic [17:0] a);
    return {|a[17:13], a[IDX_W-2:0]};
  endfunction

  st_t           st;
  logic [CW-1:0] cnt;
  logic [7:0]    mem [DEPTH];

  wire hit_a  = wr_addr == 18'h05555;
  wire hit_b  = wr_addr == 18'h02AAA;
  wire accept = wr_en && (cnt == '0);
  wire w_boot = ~|wr_addr[17:13];

  assign busy = cnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      id_mode     <= 1'b0;
      boot_locked <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (cnt != '0) cnt <= cnt - 1'b1;
      if (accept) begin
        st <= S_IDLE;
        case (st)
          S_IDLE: begin
            if (hit_a && wr_data == 8'hAA) st <= S_U1;
            else if (wr_data == 8'hF0)     id_mode <= 1'b0;
          end
          S_U1: if (hit_b && wr_data == 8'h55) st <= S_U2;
          S_U2: if (hit_a) begin
            case (wr_data)
              8'hA0:   st <= S_PGM;
              8'h80:   st <= S_E3;
              8'h90:   id_mode <= 1'b1;
              8'hF0:   id_mode <= 1'b0;
              default: ;
            endcase
          end
          S_PGM: if (!(boot_locked && w_boot)) begin
            mem[idx(wr_addr)] <= mem[idx(wr_addr)] & wr_data;
            cnt <= CW'(BUSY_CYC);
          end
          S_E3: if (hit_a && wr_data == 8'hAA) st <= S_E4;
          S_E4: if (hit_b && wr_data == 8'h55) st <= S_E5;
          S_E5: if (hit_a) begin
            if (wr_data == 8'h10) begin
              for (int i = 0; i < DEPTH; i++)
                if (i >= HALF || !boot_locked) mem[i] <= 8'hFF;
              cnt <= CW'(BUSY_CYC);
            end else if (wr_data == 8'h40) begin
              boot_locked <= 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = mem[idx(rd_addr)];
    if (id_mode) begin
      if (rd_addr == 18'd0)      rd_data = MFR_CODE;
      else if (rd_addr == 18'd1) rd_data = DEV_CODE;
      else if (rd_addr == 18'd2) rd_data = {7'd0, boot_locked};
    end
  end
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [17:0] wr_addr,
  input logic [7:0]  wr_data,
  input logic        busy,
  input logic        id_mode,
  input logic        boot_locked
);
  p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boot_locked |=> boot_locked);

  p_lock_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_locked) |-> $past(wr_en) && $past(wr_data) == 8'h40 && $past(wr_addr) == 18'h05555);

  p_id_enter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> $past(wr_en) && $past(wr_data) == 8'h90 && $past(wr_addr) == 18'h05555);

  p_id_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(id_mode) |-> $past(wr_en) && $past(wr_data) == 8'hF0);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |=> $stable(id_mode) && $stable(boot_locked));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .id_mode(id_mode), .boot_locked(boot_locked)
);

// File: tb/nor_cmd_seq_test.sv
`timescale 1ns/1ps
module nor_cmd_seq_test;
  localparam int BUSY = 8;
  localparam int NLOC = 32;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [17:0] wr_addr = 0, rd_addr = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  rd_data;
  logic busy, id_mode, boot_locked;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  nor_cmd_seq #(.IDX_W(5), .BUSY_CYC(BUSY), .MFR_CODE(8'h1F), .DEV_CODE(8'h0B)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .id_mode(id_mode),
    .boot_locked(boot_locked));

  always #2.5 clk = ~clk;

  // behavioural reference: stage counts how many cycles of a sequence are matched
  int  stage;
  int  left;
  bit  m_id, m_lock;
  byte unsigned m_arr [NLOC];

  function automatic int loc(logic [17:0] a);
    return ((a >= 18'h2000) ? NLOC / 2 : 0) + int'(a % (NLOC / 2));
  endfunction

  function automatic logic [7:0] m_read(logic [17:0] a);
    if (m_id && a == 0) return 8'h1F;
    if (m_id && a == 1) return 8'h0B;
    if (m_id && a == 2) return m_lock ? 8'h01 : 8'h00;
    return m_arr[loc(a)];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      stage = 0; left = 0; m_id = 0; m_lock = 0;
      foreach (m_arr[i]) m_arr[i] = 8'hFF;
    end else begin
      bit take;
      int nxt;
      take = wr_en && left == 0;
      if (left > 0) left--;
      if (take) begin
        nxt = 0;
        if (stage == 0 && wr_addr == 18'h5555 && wr_data == 8'hAA) nxt = 1;
        else if (stage == 0 && wr_data == 8'hF0) m_id = 0;
        else if ((stage == 1 || stage == 4) && wr_addr == 18'h2AAA && wr_data == 8'h55) nxt = stage + 1;
        else if (stage == 3 && wr_addr == 18'h5555 && wr_data == 8'hAA) nxt = 4;
        else if (stage == 2 && wr_addr == 18'h5555) begin
          if (wr_data == 8'hA0) nxt = 6;
          if (wr_data == 8'h80) nxt = 3;
          if (wr_data == 8'h90) m_id = 1;
          if (wr_data == 8'hF0) m_id = 0;
        end else if (stage == 5 && wr_addr == 18'h5555) begin
          if (wr_data == 8'h40) m_lock = 1;
          if (wr_data == 8'h10) begin
            for (int i = 0; i < NLOC; i++) if (!m_lock || i >= NLOC / 2) m_arr[i] = 8'hFF;
            left = BUSY;
          end
        end else if (stage == 6 && !(m_lock && wr_addr < 18'h2000)) begin
          m_arr[loc(wr_addr)] = m_arr[loc(wr_addr)] & wr_data;
          left = BUSY;
        end
        stage = nxt;
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk("R9 model rd_data", rd_data, m_read(rd_addr));
      chk("R8 model busy", {7'd0, busy}, {7'd0, left != 0});
      chk("R6 model id_mode", {7'd0, id_mode}, {7'd0, m_id});
      chk("R4 model boot_locked", {7'd0, boot_locked}, {7'd0, m_lock});
    end
  end

  task automatic wr(logic [17:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
  endtask
  task automatic quiet(int n);
    @(negedge clk); wr_en = 0;
    repeat (n) @(negedge clk);
  endtask
  task automatic rd_chk(string tag, logic [17:0] a, logic [7:0] exp);
    @(negedge clk); wr_en = 0; rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask
  task automatic unlock();
    wr(18'h5555, 8'hAA); wr(18'h2AAA, 8'h55);
  endtask
  task automatic prog(logic [17:0] a, logic [7:0] d);
    unlock(); wr(18'h5555, 8'hA0); wr(a, d); quiet(BUSY + 1);
  endtask
  task automatic six(logic [7:0] last);
    unlock(); wr(18'h5555, 8'h80); unlock(); wr(18'h5555, last); quiet(BUSY + 1);
  endtask

  task automatic summary();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk("R1 reset array", 18'h00100, 8'hFF);
    chk("R1 reset busy", {7'd0, busy}, 8'h00);
    chk("R1 reset id", {7'd0, id_mode}, 8'h00);
    chk("R1 reset lock", {7'd0, boot_locked}, 8'h00);

    prog(18'h02100, 8'h5A);
    rd_chk("R2 program", 18'h02100, 8'h5A);
    prog(18'h02100, 8'h0F);
    rd_chk("R2 AND of old and new", 18'h02100, 8'h0A);
    rd_chk("R9 alias upper half", 18'h04100, 8'h0A);
    prog(18'h00003, 8'h33);
    rd_chk("R2 boot program", 18'h00003, 8'h33);
    rd_chk("R9 boot alias", 18'h00013, 8'h33);

    unlock(); wr(18'h5555, 8'h12); wr(18'h02101, 8'h00); quiet(BUSY + 1);
    rd_chk("R7 bad command byte", 18'h02101, 8'hFF);
    wr(18'h5555, 8'hAA); wr(18'h1234, 8'h55); wr(18'h5555, 8'hA0); wr(18'h02101, 8'h00); quiet(BUSY + 1);
    rd_chk("R7 bad second address", 18'h02101, 8'hFF);

    unlock(); wr(18'h5555, 8'h90); quiet(1);
    rd_chk("R6 manufacturer code", 18'h0, 8'h1F);
    rd_chk("R6 device code", 18'h1, 8'h0B);
    rd_chk("R4 lock status unlocked", 18'h2, 8'h00);
    rd_chk("R6 other address array", 18'h3, 8'h33);
    wr(18'h1234, 8'hF0); quiet(1);
    rd_chk("R6 single F0 exit", 18'h0, 8'hFF);
    unlock(); wr(18'h5555, 8'h90); unlock(); wr(18'h5555, 8'hF0); quiet(1);
    rd_chk("R6 sequence exit", 18'h1, 8'hFF);

    six(8'h10);
    rd_chk("R3 erase main", 18'h02100, 8'hFF);
    rd_chk("R3 erase boot", 18'h00003, 8'hFF);

    prog(18'h00003, 8'h44);
    prog(18'h02105, 8'h11);
    six(8'h40);
    chk("R4 lock set", {7'd0, boot_locked}, 8'h01);
    unlock(); wr(18'h5555, 8'h90); quiet(1);
    rd_chk("R4 lock status locked", 18'h2, 8'h01);
    wr(18'h0, 8'hF0); quiet(1);

    prog(18'h00003, 8'h00);
    rd_chk("R5 locked program ignored", 18'h00003, 8'h44);
    six(8'h10);
    rd_chk("R5 erase keeps boot", 18'h00003, 8'h44);
    rd_chk("R5 erase clears main", 18'h02105, 8'hFF);
    chk("R4 lock sticky", {7'd0, boot_locked}, 8'h01);

    unlock(); wr(18'h5555, 8'hA0); wr(18'h02106, 8'h77);
    unlock(); wr(18'h5555, 8'hA0); wr(18'h02107, 8'h00);
    @(negedge clk); wr_en = 0; #1;
    chk("R8 busy during window", {7'd0, busy}, 8'h01);
    quiet(BUSY);
    chk("R8 busy ends", {7'd0, busy}, 8'h00);
    rd_chk("R8 programmed byte", 18'h02106, 8'h77);
    rd_chk("R8 writes while busy ignored", 18'h02107, 8'hFF);

    quiet(2);
    summary();
  end
endmodule